// File: doc/BRIEF.md
# Double-Buffered Configuration Loader

This block holds the configuration of an array of programmable elements. Every element has two word-wide registers: a staging register and a live register. The staging registers are linked into one serial chain. While loading is enabled, a new word enters at the head of the chain on each clock, and every other word moves one stage toward the tail. The array itself sees only the live registers. They keep their contents while a new configuration moves through the staging chain, so the array keeps computing during a load.

After a complete configuration has been shifted in, a single-cycle apply pulse copies every staging register into its live register on the same clock edge. The whole array therefore changes function in one cycle. The chain order follows the physical order of the elements, from the input end to the output end. Loading a full configuration takes one clock per element. The tail stage is brought out as a serial output, which can feed a further chain or be used to read the staged words back.

Top module: `cfg_dbuf_chain`

## Requirements
- R1: While `rst_n` is low, all live registers and all staging registers are cleared to zero, so `cfg_live_o` and `cfg_tail_o` read all zero after reset.
- R2: On a clock edge with `load_en` high, staging register 0 takes `cfg_word_i`, and staging register k (k ≥ 1) takes the previous value of staging register k-1.
- R3: On a clock edge with `load_en` low, every staging register keeps its value.
- R4: On a clock edge with `apply` high, every live register takes the value its staging register held before that edge, all on the same edge.
- R5: On a clock edge with `apply` low, every live register keeps its value, whether or not the chain shifts.
- R6: When `apply` and `load_en` are both high on the same edge, the live registers take the staging values from before that edge's shift.
- R7: After exactly ELEMS shifts of words numbered 0 to ELEMS-1, element k holds word ELEMS-1-k. Element k's live word appears at bits [k*WORD_W +: WORD_W] of `cfg_live_o`.
- R8: `cfg_tail_o` always equals staging register ELEMS-1. After a full load it therefore shows the first word shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Shift the staging chain by one word |
| cfg_word_i | input | WORD_W | Serial word entering the head of the chain |
| apply | input | 1 | Copy all staging registers into the live registers |
| cfg_live_o | output | ELEMS*WORD_W | Live configuration of all elements, element k at bits [k*WORD_W +: WORD_W] |
| cfg_tail_o | output | WORD_W | Staging register of the last element |

## Verification
The assertions assume that `load_en` and `apply` are known, non-X levels sampled at each edge. Any combination of the two is legal, including both at once. The bench only drives defined values, changing them half a period away from the active edge. Random cycles mix idle, shift-only, apply-only and combined cycles over random words, so every pairing of the two controls occurs. Directed full loads, followed by an apply, exercise the ordering rule.

// File: rtl/cfg_dbuf_pkg.sv
package cfg_dbuf_pkg;
    localparam int unsigned CFG_WORD_W_DEF = 32;
    localparam int unsigned CFG_ELEMS_DEF  = 128;
endpackage

// File: rtl/cfg_dbuf_stage.sv
module cfg_dbuf_stage #(
    parameter int unsigned WORD_W = cfg_dbuf_pkg::CFG_WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              apply,
    input  logic [WORD_W-1:0] shift_in,
    output logic [WORD_W-1:0] stage_o,
    output logic [WORD_W-1:0] live_o
);
    typedef struct packed {
        logic [WORD_W-1:0] stage;
        logic [WORD_W-1:0] live;
    } stage_state_t;

    stage_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.stage = shift_in;
        end
        if (apply) begin
            st_d.live = st_q.stage;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_o = st_q.stage;
    assign live_o  = st_q.live;

    AST_SHIFT_TAKES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> stage_o == $past(shift_in)); // R2
    AST_STAGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(stage_o)); // R3
    AST_APPLY_COPIES_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> live_o == $past(stage_o)); // R4 R6
    AST_LIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(live_o)); // R5
endmodule

// File: rtl/cfg_dbuf_chain.sv
module cfg_dbuf_chain #(
    parameter int unsigned WORD_W = cfg_dbuf_pkg::CFG_WORD_W_DEF,
    parameter int unsigned ELEMS  = cfg_dbuf_pkg::CFG_ELEMS_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_en,
    input  logic [WORD_W-1:0]        cfg_word_i,
    input  logic                     apply,
    output logic [ELEMS*WORD_W-1:0]  cfg_live_o,
    output logic [WORD_W-1:0]        cfg_tail_o
);
    localparam int unsigned LINKS = ELEMS + 1;

    logic [WORD_W-1:0] link [LINKS];

    assign link[0] = cfg_word_i;

    for (genvar k = 0; k < ELEMS; k++) begin : g_elem
        cfg_dbuf_stage #(.WORD_W(WORD_W)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (load_en),
            .apply    (apply),
            .shift_in (link[k]),
            .stage_o  (link[k+1]),
            .live_o   (cfg_live_o[k*WORD_W +: WORD_W])
        );
    end

    assign cfg_tail_o = link[ELEMS];

    AST_TAIL_TRACKS_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && ELEMS > 1) |=> cfg_tail_o == $past(link[ELEMS-1])); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (cfg_live_o == '0 && cfg_tail_o == '0)); // R1
endmodule

// File: tb/tb_cfg_dbuf_chain.sv
`timescale 1ns/1ps
module tb_cfg_dbuf_chain;
    localparam int unsigned W = 16;
    localparam int unsigned N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_en = 1'b0;
    logic apply = 1'b0;
    logic [W-1:0] word_i = '0;
    logic [N*W-1:0] live_o;
    logic [W-1:0] tail_o;

    int tests = 0;
    int fails = 0;
    logic [W-1:0] m_stage [N];
    logic [W-1:0] m_live  [N];

    always #4 clk = ~clk;

    cfg_dbuf_chain #(.WORD_W(W), .ELEMS(N)) dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .cfg_word_i(word_i),
        .apply(apply), .cfg_live_o(live_o), .cfg_tail_o(tail_o)
    );

    function automatic logic [N*W-1:0] exp_live();
        logic [N*W-1:0] v;
        for (int k = 0; k < N; k++) v[k*W +: W] = m_live[k];
        return v;
    endfunction

    task automatic check(input string tag, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic le, input logic ap, input logic [W-1:0] w, input string tag);
        @(negedge clk);
        load_en = le; apply = ap; word_i = w;
        @(posedge clk);
        if (ap) for (int k = 0; k < N; k++) m_live[k] = m_stage[k];
        if (le) begin
            for (int k = N-1; k > 0; k--) m_stage[k] = m_stage[k-1];
            m_stage[0] = w;
        end
        #2;
        check({tag, " live"}, live_o, exp_live());
        check({tag, " tail R8"}, {{(N*W-W){1'b0}}, tail_o}, {{(N*W-W){1'b0}}, m_stage[N-1]});
    endtask

    initial begin
        #150000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int k = 0; k < N; k++) begin m_stage[k] = '0; m_live[k] = '0; end
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset live", live_o, '0);
        check("R1 reset tail", {{(N*W-W){1'b0}}, tail_o}, '0);
        @(negedge clk); rst_n = 1'b1;

        // R7: full load with live held (R5), then apply (R4)
        for (int i = 0; i < N; i++) step(1'b1, 1'b0, W'(16'hA000 + i), "R5 R2 load");
        check("R8 tail first word", {{(N*W-W){1'b0}}, tail_o}, {{(N*W-W){1'b0}}, W'(16'hA000)});
        step(1'b0, 1'b1, '0, "R4 apply");
        for (int k = 0; k < N; k++) begin
            tests++;
            if (live_o[k*W +: W] !== W'(16'hA000 + N-1-k)) begin
                fails++;
                $display("FAIL R7 elem %0d actual=%h expected=%h", k, live_o[k*W +: W], W'(16'hA000 + N-1-k));
            end
        end
        // R3: idle cycles keep everything
        repeat (3) step(1'b0, 1'b0, 16'hFFFF, "R3 idle");
        // R6: apply together with shift
        step(1'b1, 1'b0, 16'h1234, "R2 shift");
        step(1'b1, 1'b1, 16'h5678, "R6 apply+shift");
        tests++;
        if (live_o[0 +: W] !== 16'h1234) begin
            fails++;
            $display("FAIL R6 actual=%h expected=%h", live_o[0 +: W], 16'h1234);
        end
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [1:0] r;
            r = 2'($urandom);
            step(r[0], r[1], W'($urandom), "R2 R3 R4 R5 random");
        end
        // R1: reset mid-run clears again
        @(negedge clk); rst_n = 1'b0; load_en = 1'b0; apply = 1'b0;
        for (int k = 0; k < N; k++) begin m_stage[k] = '0; m_live[k] = '0; end
        #2;
        check("R1 reset again", live_o, '0);
        check("R1 reset again tail", {{(N*W-W){1'b0}}, tail_o}, '0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule